// File: doc/BRIEF.md
# Asynchronous Bus Cycle Controller with Error Abort

This block is the bus master sequencer for a request/acknowledge bus. A single command (read, write, or read-modify-write) starts a cycle. The controller then steps through numbered bus states, one state per clock. It drives the address strobe, the data strobe and the direction line, and it waits in a fixed wait state until the responding device answers with a data acknowledge. Acknowledge, bus error and halt come from outside the clock domain. Each of them passes through a two-flop synchronizer before the state machine looks at it.

A responder that never answers is handled by the bus error input. When a valid error is recognised, the cycle is cut short. It ends in a termination state chosen by two things: whether acknowledge came together with the error, and which part of a read-modify-write cycle was running. The controller then reports the faulting address, the direction, a read-modify-write flag and the termination state on a one-cycle error report. It raises an exception request only once the error input has been removed. The write-data enable is forced off for as long as the raw error input stays high.

Top module: `async_bus_master`

## Requirements
- R1: A command is accepted only while `busy` is low. The kind encoding is 0 = read, 1 = write, 2 = read-modify-write, and 3 is treated as a read. States advance once per clock from S0. `addrStrobe` rises exactly once per command, at S2, and stays high without a gap until the last state, across both portions of a read-modify-write.
- R2: A bus error is recognised only when the synchronised error input is high and the synchronised halt input is low. With halt high, an asserted error is ignored: the cycle keeps waiting, and when acknowledge arrives it completes normally with `cycDone` and no error report.
- R3: In a plain read or write, an error without acknowledge ends the cycle in S9, and an error together with acknowledge ends it in S7. No `cycDone` pulse is given for an aborted cycle.
- R4: In the read portion of a read-modify-write (states below S12, wait state S4), any recognised error ends the cycle in S11.
- R5: In the write portion of a read-modify-write (S12 onward, wait state S16), an error without acknowledge ends the cycle in S21, and an error together with acknowledge ends it in S19.
- R6: `busDoe` is low in every cycle in which `berrIn` is high.
- R7: After an abort, `excReq` pulses once. It does so only after the terminating state has passed and the synchronised error input has gone low, and never while `berrIn` is high.
- R8: An abort produces a single-cycle `errValid` pulse. With it come `errAddr` (the command address), `errWrite` (1 when the failing portion was a write), `errRmw` (1 for a read-modify-write) and `errState` (the termination state number).
- R9: A read or read-modify-write that completes without error gives a one-cycle `cycDone` pulse, and `rdData` then holds the `busDin` value sampled in S6 of the read portion.
- R10: During a plain write, or during the write portion of a read-modify-write, `readNotWrite` is low. While the data strobe is high there and `berrIn` is low, `busDoe` is high, `busDout` equals the command data and `busAddr` equals the command address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Start a bus cycle (taken only when idle) |
| cmdKind | input | 2 | 0 read, 1 write, 2 read-modify-write |
| cmdAddr | input | AW (24) | Cycle address |
| cmdWdata | input | DW (16) | Write data |
| busy | output | 1 | A cycle or an error wait is in progress |
| cycDone | output | 1 | One-cycle pulse at normal completion |
| rdData | output | DW (16) | Data captured by the last good read |
| ackIn | input | 1 | Asynchronous data acknowledge, active high |
| berrIn | input | 1 | Asynchronous bus error, active high |
| haltIn | input | 1 | Asynchronous halt, active high |
| addrStrobe | output | 1 | Address strobe |
| dataStrobe | output | 1 | Data strobe |
| readNotWrite | output | 1 | 1 read, 0 write |
| busAddr | output | AW (24) | Address bus |
| busDout | output | DW (16) | Write data towards the bus |
| busDin | input | DW (16) | Read data from the bus |
| busDoe | output | 1 | Output enable for the write data drivers |
| errValid | output | 1 | One-cycle error report pulse |
| errAddr | output | AW (24) | Address of the aborted cycle |
| errWrite | output | 1 | Aborted portion was a write |
| errRmw | output | 1 | Aborted cycle was read-modify-write |
| errState | output | SW (5) | Termination state number |
| excReq | output | 1 | Bus error exception request pulse |

## Verification
The assertions assume that the handshake inputs behave like a real responder. Acknowledge, error and halt are held for several clocks once raised, so the synchronised copies follow them. Acknowledge is withdrawn only after the data strobe falls, and error only after the report has been seen. The stimulus respects this. It raises acknowledge or error only once the data strobe is visible, keeps them high across the termination, and drops them after the strobe or the report. It also leaves idle clocks between commands, so the synchronisers are clear before the next wait state.

// File: rtl/busctl_pkg.sv
package busctl_pkg;
  typedef enum logic [1:0] {
    K_READ  = 2'd0,
    K_WRITE = 2'd1,
    K_RMW   = 2'd2
  } busKind_t;

  typedef enum logic [1:0] {
    PH_IDLE    = 2'd0,
    PH_RUN     = 2'd1,
    PH_ERRWAIT = 2'd2
  } phase_t;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic loadCmd;
    logic latchRd;
    logic latchErr;
    logic writeNow;
  } ctlStrobe_t;
endpackage

// File: rtl/busctl_sync.sv
module busctl_sync #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stage1 <= '0;
      dout   <= '0;
    end else begin
      stage1 <= din;
      dout   <= stage1;
    end
  end
endmodule

// File: rtl/busctl_ctrl.sv
module busctl_ctrl
  import busctl_pkg::*;
#(
  parameter int SW = 5
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          cmdValid,
  input  logic [1:0]    cmdKind,
  input  logic          ackS,
  input  logic          berrS,
  input  logic          haltS,
  output ctlStrobe_t    strobe,
  output logic          busy,
  output logic          cycDone,
  output logic          excReq,
  output logic          addrStrobe,
  output logic          dataStrobe,
  output logic          readNotWrite,
  output logic [SW-1:0] stNow,
  output logic          isRmw
);
  localparam logic [SW-1:0] ST_AS_ON     = SW'(2);
  localparam logic [SW-1:0] ST_WAIT_RD   = SW'(4);
  localparam logic [SW-1:0] ST_WR_DS_A   = SW'(4);
  localparam logic [SW-1:0] ST_RD_LATCH  = SW'(6);
  localparam logic [SW-1:0] ST_END_OK    = SW'(7);
  localparam logic [SW-1:0] ST_END_NOACK = SW'(9);
  localparam logic [SW-1:0] ST_END_RMWRD = SW'(11);
  localparam logic [SW-1:0] ST_SPLIT     = SW'(12);
  localparam logic [SW-1:0] ST_WR_DS_B   = SW'(14);
  localparam logic [SW-1:0] ST_WAIT_WR   = SW'(16);
  localparam logic [SW-1:0] ST_END_RMWOK = SW'(19);
  localparam logic [SW-1:0] ST_END_RMWNA = SW'(21);

  phase_t        phase;
  busKind_t      kindR;
  logic [SW-1:0] st;
  logic          abortR;
  logic          ackWithErr;

  logic          rmwWr;
  logic          errEvt;
  logic [SW-1:0] waitSt;
  logic [SW-1:0] endSt;
  logic [SW-1:0] portEnd;
  logic [SW-1:0] dsFirst;

  always_comb begin
    rmwWr  = (kindR == K_RMW) && (st >= ST_SPLIT);
    waitSt = rmwWr ? ST_WAIT_WR : ST_WAIT_RD;
    errEvt = berrS && !haltS;

    if (!abortR) begin
      endSt = (kindR == K_RMW) ? ST_END_RMWOK : ST_END_OK;
    end else if (kindR != K_RMW) begin
      endSt = ackWithErr ? ST_END_OK : ST_END_NOACK;
    end else if (rmwWr) begin
      endSt = ackWithErr ? ST_END_RMWOK : ST_END_RMWNA;
    end else begin
      endSt = ST_END_RMWRD;
    end

    if (!abortR && (kindR == K_RMW) && !rmwWr) portEnd = ST_END_OK;
    else                                       portEnd = endSt;

    readNotWrite = !((phase == PH_RUN) && ((kindR == K_WRITE) || rmwWr));
    dsFirst      = readNotWrite ? ST_AS_ON : (rmwWr ? ST_WR_DS_B : ST_WR_DS_A);
    addrStrobe   = (phase == PH_RUN) && (st >= ST_AS_ON);
    dataStrobe   = (phase == PH_RUN) && (st >= dsFirst) && (st <= portEnd);

    strobe.loadCmd  = (phase == PH_IDLE) && cmdValid;
    strobe.latchRd  = (phase == PH_RUN) && (st == ST_RD_LATCH) && readNotWrite && !abortR;
    strobe.latchErr = (phase == PH_RUN) && abortR && (st == endSt);
    strobe.writeNow = (phase == PH_RUN) && !readNotWrite;

    busy  = (phase != PH_IDLE);
    stNow = st;
    isRmw = (kindR == K_RMW);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase      <= PH_IDLE;
      kindR      <= K_READ;
      st         <= '0;
      abortR     <= 1'b0;
      ackWithErr <= 1'b0;
      cycDone    <= 1'b0;
      excReq     <= 1'b0;
    end else begin
      cycDone <= 1'b0;
      excReq  <= 1'b0;
      case (phase)
        PH_IDLE: begin
          if (cmdValid) begin
            phase      <= PH_RUN;
            st         <= '0;
            abortR     <= 1'b0;
            ackWithErr <= 1'b0;
            kindR      <= (cmdKind == 2'd3) ? K_READ : busKind_t'(cmdKind);
          end
        end
        PH_RUN: begin
          if ((st == waitSt) && !abortR) begin
            if (errEvt) begin
              abortR     <= 1'b1;
              ackWithErr <= ackS;
              st         <= st + 1'b1;
            end else if (ackS) begin
              st <= st + 1'b1;
            end
          end else if (st == endSt) begin
            if (abortR) begin
              phase <= PH_ERRWAIT;
            end else begin
              phase   <= PH_IDLE;
              cycDone <= 1'b1;
            end
          end else begin
            st <= st + 1'b1;
          end
        end
        PH_ERRWAIT: begin
          if (!berrS) begin
            excReq <= 1'b1;
            phase  <= PH_IDLE;
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  // R1: address strobe is never dropped while the cycle is still running
  p_as_held_r1: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_RUN && addrStrobe) |=> (addrStrobe || phase != PH_RUN));

  // R2: an error seen together with halt never starts an abort
  p_halt_mask_r2: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_RUN && st == waitSt && !abortR && haltS) |=> !abortR);

  p_plain_end_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.latchErr && kindR != K_RMW) |-> (st == ST_END_OK || st == ST_END_NOACK));

  p_rmw_rd_end_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.latchErr && kindR == K_RMW && !rmwWr) |-> (st == ST_END_RMWRD));

  p_rmw_wr_end_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.latchErr && rmwWr) |-> (st == ST_END_RMWOK || st == ST_END_RMWNA));

  // R7: exception request only follows an error wait with the error removed
  p_exc_after_r7: assert property (@(posedge clk) disable iff (!rstN)
    excReq |-> $past(phase == PH_ERRWAIT && !berrS));
endmodule

// File: rtl/busctl_dp.sv
module busctl_dp
  import busctl_pkg::*;
#(
  parameter int AW = 24,
  parameter int DW = 16,
  parameter int SW = 5
) (
  input  logic          clk,
  input  logic          rstN,
  input  ctlStrobe_t    strobe,
  input  logic [AW-1:0] cmdAddr,
  input  logic [DW-1:0] cmdWdata,
  input  logic [DW-1:0] busDin,
  input  logic          berrIn,
  input  logic          readNotWrite,
  input  logic [SW-1:0] stNow,
  input  logic          isRmw,
  output logic [AW-1:0] busAddr,
  output logic [DW-1:0] busDout,
  output logic          busDoe,
  output logic [DW-1:0] rdData,
  output logic          errValid,
  output logic [AW-1:0] errAddr,
  output logic          errWrite,
  output logic          errRmw,
  output logic [SW-1:0] errState
);
  logic [AW-1:0] addrR;
  logic [DW-1:0] wdataR;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrR    <= '0;
      wdataR   <= '0;
      rdData   <= '0;
      errValid <= 1'b0;
      errAddr  <= '0;
      errWrite <= 1'b0;
      errRmw   <= 1'b0;
      errState <= '0;
    end else begin
      errValid <= 1'b0;
      if (strobe.loadCmd) begin
        addrR  <= cmdAddr;
        wdataR <= cmdWdata;
      end
      if (strobe.latchRd) rdData <= busDin;
      if (strobe.latchErr) begin
        errValid <= 1'b1;
        errAddr  <= addrR;
        errWrite <= !readNotWrite;
        errRmw   <= isRmw;
        errState <= stNow;
      end
    end
  end

  always_comb begin
    busAddr = addrR;
    busDout = wdataR;
    busDoe  = strobe.writeNow && !berrIn;
  end

  // R8: each abort gives exactly one report cycle
  p_err_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    errValid |=> !errValid);
endmodule

// File: rtl/async_bus_master.sv
module async_bus_master
  import busctl_pkg::*;
#(
  parameter int AW = 24,
  parameter int DW = 16,
  parameter int SW = 5
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          cmdValid,
  input  logic [1:0]    cmdKind,
  input  logic [AW-1:0] cmdAddr,
  input  logic [DW-1:0] cmdWdata,
  output logic          busy,
  output logic          cycDone,
  output logic [DW-1:0] rdData,
  input  logic          ackIn,
  input  logic          berrIn,
  input  logic          haltIn,
  output logic          addrStrobe,
  output logic          dataStrobe,
  output logic          readNotWrite,
  output logic [AW-1:0] busAddr,
  output logic [DW-1:0] busDout,
  input  logic [DW-1:0] busDin,
  output logic          busDoe,
  output logic          errValid,
  output logic [AW-1:0] errAddr,
  output logic          errWrite,
  output logic          errRmw,
  output logic [SW-1:0] errState,
  output logic          excReq
);
  localparam int NSYNC = 3;

  logic [NSYNC-1:0] syncOut;
  ctlStrobe_t       strobe;
  logic [SW-1:0]    stNow;
  logic             isRmw;

  busctl_sync #(.W(NSYNC)) u_sync (
    .clk (clk),
    .rstN(rstN),
    .din ({haltIn, berrIn, ackIn}),
    .dout(syncOut)
  );

  busctl_ctrl #(.SW(SW)) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .cmdValid    (cmdValid),
    .cmdKind     (cmdKind),
    .ackS        (syncOut[0]),
    .berrS       (syncOut[1]),
    .haltS       (syncOut[2]),
    .strobe      (strobe),
    .busy        (busy),
    .cycDone     (cycDone),
    .excReq      (excReq),
    .addrStrobe  (addrStrobe),
    .dataStrobe  (dataStrobe),
    .readNotWrite(readNotWrite),
    .stNow       (stNow),
    .isRmw       (isRmw)
  );

  busctl_dp #(.AW(AW), .DW(DW), .SW(SW)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .cmdAddr     (cmdAddr),
    .cmdWdata    (cmdWdata),
    .busDin      (busDin),
    .berrIn      (berrIn),
    .readNotWrite(readNotWrite),
    .stNow       (stNow),
    .isRmw       (isRmw),
    .busAddr     (busAddr),
    .busDout     (busDout),
    .busDoe      (busDoe),
    .rdData      (rdData),
    .errValid    (errValid),
    .errAddr     (errAddr),
    .errWrite    (errWrite),
    .errRmw      (errRmw),
    .errState    (errState)
  );

  // R10: drivers are enabled only while the controller is in a write portion
  p_doe_dir_r10: assert property (@(posedge clk) disable iff (!rstN)
    busDoe |-> !readNotWrite);
endmodule

// File: tb/async_bus_master_tb.sv
module async_bus_master_tb;
  localparam int AW = 24;
  localparam int DW = 16;
  localparam int SW = 5;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          cmdValid = 1'b0;
  logic [1:0]    cmdKind = 2'd0;
  logic [AW-1:0] cmdAddr = '0;
  logic [DW-1:0] cmdWdata = '0;
  logic          busy, cycDone;
  logic [DW-1:0] rdData;
  logic          ackIn = 1'b0, berrIn = 1'b0, haltIn = 1'b0;
  logic          addrStrobe, dataStrobe, readNotWrite;
  logic [AW-1:0] busAddr;
  logic [DW-1:0] busDout;
  logic [DW-1:0] busDin = '0;
  logic          busDoe, errValid, errWrite, errRmw, excReq;
  logic [AW-1:0] errAddr;
  logic [SW-1:0] errState;

  always #2 clk = ~clk;  // 4 ns period

  async_bus_master #(.AW(AW), .DW(DW), .SW(SW)) u_dut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdKind(cmdKind),
    .cmdAddr(cmdAddr), .cmdWdata(cmdWdata), .busy(busy), .cycDone(cycDone),
    .rdData(rdData), .ackIn(ackIn), .berrIn(berrIn), .haltIn(haltIn),
    .addrStrobe(addrStrobe), .dataStrobe(dataStrobe), .readNotWrite(readNotWrite),
    .busAddr(busAddr), .busDout(busDout), .busDin(busDin), .busDoe(busDoe),
    .errValid(errValid), .errAddr(errAddr), .errWrite(errWrite), .errRmw(errRmw),
    .errState(errState), .excReq(excReq)
  );

  int total = 0, bad = 0;
  int monTotal = 0, monBad = 0;
  int errCnt = 0, doneCnt = 0, excCnt = 0, asRise = 0;
  logic prevErr = 1'b0, prevAs = 1'b0;

  // continuous port monitor
  always @(negedge clk) begin
    if (rstN) begin
      monTotal++;
      if (berrIn && busDoe) begin
        monBad++; $display("FAIL R6: busDoe actual=1 expected=0 while berrIn high");
      end
      if (excReq && berrIn) begin
        monBad++; $display("FAIL R7: excReq actual=1 expected=0 while berrIn high");
      end
      if (errValid && prevErr) begin
        monBad++; $display("FAIL R8: errValid actual=1 expected=0 on second cycle");
      end
      if (errValid) errCnt++;
      if (cycDone) doneCnt++;
      if (excReq) excCnt++;
      if (addrStrobe && !prevAs) asRise++;
      prevErr = errValid;
      prevAs  = addrStrobe;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int expEnd(input int kind, input bit wrPart, input bit withAck);
    if (kind == 2) return wrPart ? (withAck ? 19 : 21) : 11;
    return withAck ? 7 : 9;
  endfunction

  function automatic string endReq(input int kind, input bit wrPart);
    if (kind == 2) return wrPart ? "R5" : "R4";
    return "R3";
  endfunction

  task automatic startCmd(input int kind, input logic [AW-1:0] a, input logic [DW-1:0] wd);
    for (int n = 0; n < 100 && busy; n++) @(negedge clk);
    cmdKind = kind[1:0]; cmdAddr = a; cmdWdata = wd; cmdValid = 1'b1;
    @(negedge clk);
    cmdValid = 1'b0;
  endtask

  task automatic waitDs(input bit wantWrite, input logic [AW-1:0] a, input logic [DW-1:0] wd);
    int n = 0;
    while (!(dataStrobe && (!wantWrite || !readNotWrite)) && n < 100) begin
      @(negedge clk); n++;
    end
    check(n < 100, "R1", "data strobe seen", n, 0);
    if (wantWrite && !berrIn) begin
      check(busDoe == 1'b1 && readNotWrite == 1'b0, "R10", "write enable/dir",
            {busDoe, readNotWrite}, 2'b10);
      check(busDout == wd, "R10", "write data", busDout, wd);
      check(busAddr == a, "R10", "address", busAddr, a);
    end
  endtask

  task automatic waitDsLow();
    for (int n = 0; n < 100 && dataStrobe; n++) @(negedge clk);
  endtask

  task automatic ackPortion(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] wd);
    waitDs(wr, a, wd);
    ackIn = 1'b1;
    waitDsLow();
    ackIn = 1'b0;
  endtask

  task automatic waitDone(input int d0);
    for (int n = 0; n < 100 && doneCnt == d0; n++) @(negedge clk);
  endtask

  // scen: 0 normal, 1 error alone, 2 error with ack, 3 error masked by halt
  task automatic runTx(input int kind, input int scen, input bit wrPartIn,
                       input logic [AW-1:0] a, input logic [DW-1:0] wd, input logic [DW-1:0] rd);
    int e0, d0, x0, a0;
    bit rmw, wrPart, withAck;
    rmw = (kind == 2);
    wrPart = rmw && wrPartIn;
    busDin = rd;
    e0 = errCnt; d0 = doneCnt; x0 = excCnt; a0 = asRise;
    startCmd(kind, a, wd);
    case (scen)
      0: begin
        ackPortion(kind == 1, a, wd);
        if (rmw) ackPortion(1'b1, a, wd);
        waitDone(d0);
        check(doneCnt == d0 + 1, "R9", "cycDone count", doneCnt - d0, 1);
        if (kind != 1) check(rdData == rd, "R9", "read data", rdData, rd);
        check(errCnt == e0, "R9", "no error report", errCnt - e0, 0);
      end
      1, 2: begin
        withAck = (scen == 2);
        if (wrPart) begin
          ackPortion(1'b0, a, wd);
          waitDs(1'b1, a, wd);
        end else begin
          waitDs(kind == 1, a, wd);
        end
        berrIn = 1'b1; ackIn = withAck;
        for (int n = 0; n < 100 && errCnt == e0; n++) @(negedge clk);
        check(errCnt == e0 + 1, "R8", "error report count", errCnt - e0, 1);
        check(errState == SW'(expEnd(kind, wrPart, withAck)), endReq(kind, wrPart),
              "termination state", errState, expEnd(kind, wrPart, withAck));
        check(errAddr == a, "R8", "errAddr", errAddr, a);
        check(errWrite == (kind == 1 || wrPart), "R8", "errWrite", errWrite, (kind == 1 || wrPart));
        check(errRmw == rmw, "R8", "errRmw", errRmw, rmw);
        for (int n = 0; n < 4; n++) @(negedge clk);
        check(excCnt == x0, "R7", "no excReq while error held", excCnt - x0, 0);
        check(busy == 1'b1, "R7", "busy while error held", busy, 1);
        berrIn = 1'b0; ackIn = 1'b0;
        for (int n = 0; n < 10 && excCnt == x0; n++) @(negedge clk);
        check(excCnt == x0 + 1, "R7", "excReq after release", excCnt - x0, 1);
        check(doneCnt == d0, "R3", "no cycDone on abort", doneCnt - d0, 0);
      end
      default: begin
        waitDs(kind == 1, a, wd);
        haltIn = 1'b1; berrIn = 1'b1;
        for (int n = 0; n < 8; n++) @(negedge clk);
        check(errCnt == e0, "R2", "no error with halt", errCnt - e0, 0);
        check(busy && dataStrobe, "R2", "still waiting", {busy, dataStrobe}, 2'b11);
        if (kind == 1) check(busDoe == 1'b0, "R6", "busDoe off under error", busDoe, 0);
        ackIn = 1'b1;
        waitDsLow();
        ackIn = 1'b0; berrIn = 1'b0; haltIn = 1'b0;
        if (rmw) ackPortion(1'b1, a, wd);
        waitDone(d0);
        check(doneCnt == d0 + 1, "R2", "normal completion", doneCnt - d0, 1);
        check(errCnt == e0, "R2", "no error report", errCnt - e0, 0);
        if (kind != 1) check(rdData == rd, "R9", "read data after halt case", rdData, rd);
      end
    endcase
    check(asRise == a0 + 1, "R1", "single address strobe", asRise - a0, 1);
    for (int n = 0; n < 3; n++) @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (4) @(negedge clk);
    check(busy == 0 && addrStrobe == 0 && dataStrobe == 0, "R1", "reset strobes",
          {busy, addrStrobe, dataStrobe}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(readNotWrite == 1'b1, "R1", "reset direction", readNotWrite, 1);
    check(busDoe == 1'b0, "R6", "reset enable", busDoe, 0);
    check(errValid == 0 && excReq == 0 && cycDone == 0, "R8", "reset pulses",
          {errValid, excReq, cycDone}, 0);
    // directed: every kind against every scenario, both rmw portions
    for (int k = 0; k < 3; k++)
      for (int s = 0; s < 4; s++)
        for (int w = 0; w < 2; w++)
          if (w == 0 || k == 2)
            runTx(k, s, w[0], AW'($urandom), DW'($urandom), DW'($urandom));
    // code 3 behaves as a read
    runTx(3, 0, 1'b0, 24'h00ABCD, 16'h1234, 16'hBEEF);
    // random mix
    for (int i = 0; i < 40; i++)
      runTx(int'($urandom % 3), int'($urandom % 4), 1'($urandom),
            AW'($urandom), DW'($urandom), DW'($urandom));
    total += monTotal; bad += monBad;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("test done: total=%0d bad=%0d", total + monTotal + 1, bad + monBad + 1);
    $finish;
  end
endmodule